// File: doc/BRIEF.md
# Serial Result Read Port

This block hands a finished conversion word to a host over a read-only serial link. When the conversion sequencer strobes a new result, the port captures the parallel word and lowers its data-ready flag. The host then pulls its active-low select low and supplies its own shift clock. The port drives the word out one bit per shift-clock falling edge, most significant bit first.

Both host signals are sampled in the master-clock domain through synchronisers. Shift-clock edges are found by comparing successive synchronised samples. The serial data line has a separate output enable, so it can be built as a tri-state pin. A result that arrives while a read is in progress is held back until that read ends, so the word being shifted never changes under the host.

Top module: `serial_result_port`

## Requirements
- R1: After reset the data output enable `sdata_oe_o` is 0 and `drdy_no` is 1, meaning no result is held.
- R2: A `load_i` pulse while `drdy_no` is 1 captures `data_i`, and `drdy_no` reads 0 on the next master clock.
- R3: A high-to-low transition of `cs_ni` while `drdy_no` is 0 is recognised within SYNC_STAGES master clocks. From then on `sdata_oe_o` is 1 and `sdata_o` carries bit WORD_W-1 of the held word.
- R4: A `cs_ni` transition to low that happens while `drdy_no` is 1 is not recognised, even after a word is loaded later. `sdata_oe_o` stays 0 until `cs_ni` returns high and falls again.
- R5: After recognition, falling `sclk_i` edges do not advance the shifter until a rising `sclk_i` edge has been seen.
- R6: Once shifting is enabled, each falling `sclk_i` edge advances `sdata_o` to the next lower bit. `sdata_o` does not change on rising edges or between edges.
- R7: The falling `sclk_i` edge after the last bit (bit 0) has been driven sets `sdata_oe_o` to 0. If no further result is waiting, `drdy_no` returns to 1. While `drdy_no` is 1, `sdata_oe_o` is always 0.
- R8: If `cs_ni` goes high during shifting, the bit being driven stays on `sdata_o` with `sdata_oe_o` at 1 until the next falling `sclk_i` edge. After that edge `sdata_oe_o` is 0, and the unread word is dropped (`drdy_no` goes to 1 when nothing is waiting).
- R9: A `load_i` pulse during a read does not change the bits being shifted. After that read ends, the new word is held with `drdy_no` at 0, and it is read out in full by the next select.
- R10: A `load_i` pulse while a word is held but not yet selected replaces that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe: new result on data_i |
| data_i | input | WORD_W | Parallel conversion result |
| sclk_i | input | 1 | Host shift clock, asynchronous |
| cs_ni | input | 1 | Host select, active low, asynchronous |
| sdata_o | output | 1 | Serial data, MSB first |
| sdata_oe_o | output | 1 | Output enable for sdata_o (0 = high impedance) |
| drdy_no | output | 1 | 0 while a result is held or being read |

## Verification
The bench builds the port with its defaults: a 20-bit word and two synchroniser stages. With these values the full shift to bit 0, and the end-of-read transition that follows it, are exercised on the real width. The two-stage setting fixes the select recognition latency that the bench samples against. Every host edge is held for several master clocks, so each synchronised edge is seen exactly once. This lets the bench place a load pulse, a select release or an early shift-clock fall at a chosen bit position of a read.

// File: rtl/serport_pkg.sv
package serport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_ARMED,
    ST_SHIFT,
    ST_DRAIN
  } port_state_e;
endpackage

// File: rtl/serport_sync.sv
module serport_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stg_in;
    if (g == 0) begin : g_first
      assign stg_in = d_i;
    end else begin : g_next
      assign stg_in = stg_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else         stg_q[g] <= stg_in;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/serport_edge.sv
module serport_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/serport_ctrl.sv
module serport_ctrl
  import serport_pkg::*;
#(
  parameter int unsigned WORD_W = 20,
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              drdy_no,
  output port_state_e       state_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  port_state_e       state_q, state_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] shadow_q, shadow_d;
  logic              pend_q, pend_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              finish;
  logic              busy;

  always_comb begin
    state_d  = state_q;
    shreg_d  = shreg_q;
    shadow_d = shadow_q;
    pend_d   = pend_q;
    cnt_d    = cnt_q;
    finish   = 1'b0;
    busy     = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (load_i) begin
          shreg_d = data_i;
          state_d = ST_READY;
        end
      end
      ST_READY: begin
        if (cs_fall_i) begin
          state_d = ST_ARMED;
          cnt_d   = '0;
          busy    = 1'b1;  // MSB already on the pin this cycle
        end else if (load_i) begin
          shreg_d = data_i;
        end
      end
      ST_ARMED: begin
        busy = 1'b1;
        if (cs_rise_i)        finish  = 1'b1;
        else if (sclk_rise_i) state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        busy = 1'b1;
        if (sclk_fall_i) begin
          if (cnt_q == LAST_BIT || cs_rise_i) begin
            finish = 1'b1;
          end else begin
            shreg_d = {shreg_q[WORD_W-2:0], 1'b0};
            cnt_d   = cnt_q + 1'b1;
          end
        end else if (cs_rise_i) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        busy = 1'b1;
        if (sclk_fall_i) finish = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase

    if (finish) begin
      pend_d = 1'b0;
      if (load_i) begin
        shreg_d = data_i;
        state_d = ST_READY;
      end else if (pend_q) begin
        shreg_d = shadow_q;
        state_d = ST_READY;
      end else begin
        state_d = ST_IDLE;
      end
    end else if (busy && load_i) begin
      shadow_d = data_i;
      pend_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      state_q  <= state_d;
      shreg_q  <= shreg_d;
      shadow_q <= shadow_d;
      pend_q   <= pend_d;
      cnt_q    <= cnt_d;
    end
  end

  assign sdata_o    = shreg_q[WORD_W-1];
  assign sdata_oe_o = (state_q == ST_ARMED) || (state_q == ST_SHIFT) ||
                      (state_q == ST_DRAIN) || (state_q == ST_READY && cs_fall_i);
  assign drdy_no    = (state_q == ST_IDLE);
  assign state_o    = state_q;
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
  import serport_pkg::*;
#(
  parameter int unsigned WORD_W      = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              sclk_i,
  input  logic              cs_ni,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              drdy_no
);
  logic        sclk_s, cs_s;
  logic        sclk_rise, sclk_fall, cs_rise, cs_fall;
  port_state_e state;

  serport_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sclk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s)
  );

  serport_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_s)
  );

  serport_edge #(.RST_VAL(1'b0)) i_sclk_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_s), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  serport_edge #(.RST_VAL(1'b1)) i_cs_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_s), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  serport_ctrl #(.WORD_W(WORD_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .data_i      (data_i),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .sdata_o     (sdata_o),
    .sdata_oe_o  (sdata_oe_o),
    .drdy_no     (drdy_no),
    .state_o     (state)
  );
endmodule

// File: rtl/serial_result_port_chk.sv
module serial_result_port_chk
  import serport_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        load_i,
  input logic        sdata_o,
  input logic        sdata_oe_o,
  input logic        drdy_no,
  input logic        sclk_fall,
  input logic        cs_rise,
  input port_state_e state
);
  assert_idle_hiz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_no |-> !sdata_oe_o);

  assert_load_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && drdy_no) |=> !drdy_no);

  assert_load_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !drdy_no) |=> !drdy_no);

  assert_sdata_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && $past(sdata_oe_o) && !$past(sclk_fall)) |-> $stable(sdata_o));

  assert_fall_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ARMED && sclk_fall && !cs_rise) |=> (state == ST_ARMED && $stable(sdata_o)));
endmodule

bind serial_result_port serial_result_port_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .sdata_o    (sdata_o),
  .sdata_oe_o (sdata_oe_o),
  .drdy_no    (drdy_no),
  .sclk_fall  (sclk_fall),
  .cs_rise    (cs_rise),
  .state      (state)
);

// File: tb/test_serial_result_port.sv
module test_serial_result_port;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] data = '0;
  logic         sclk = 1'b0;
  logic         cs_n = 1'b1;
  logic         sdata, sdata_oe, drdy_n;
  int           n_run = 0;
  int           n_fail = 0;

  always #4 clk = ~clk;

  serial_result_port #(.WORD_W(W), .SYNC_STAGES(2)) i_serial_result_port (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load), .data_i(data),
    .sclk_i(sclk), .cs_ni(cs_n),
    .sdata_o(sdata), .sdata_oe_o(sdata_oe), .drdy_no(drdy_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic load_word(input logic [W-1:0] w);
    data = w; load = 1'b1;
    tick(1);
    load = 1'b0;
  endtask

  task automatic select(input logic [W-1:0] w);
    cs_n = 1'b0;
    tick(3);
    chk(sdata_oe === 1'b1, "R3 oe", 32'(sdata_oe), 1);
    chk(sdata === w[W-1], "R3 msb", 32'(sdata), 32'(w[W-1]));
  endtask

  task automatic shift_bits(input logic [W-1:0] w, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      sclk = 1'b1;
      tick(2);
      chk(sdata === w[W-1-i], "R6 rise", 32'(sdata), 32'(w[W-1-i]));
      tick(4);
      chk(sdata === w[W-1-i] && sdata_oe === 1'b1, "R6 bit", 32'(sdata), 32'(w[W-1-i]));
      sclk = 1'b0;
      tick(6);
    end
  endtask

  task automatic end_check(input logic exp_drdy_n);
    chk(sdata_oe === 1'b0, "R7 hiz", 32'(sdata_oe), 0);
    chk(drdy_n === exp_drdy_n, "R7 drdy", 32'(drdy_n), 32'(exp_drdy_n));
    cs_n = 1'b1;
    tick(4);
  endtask

  task automatic t_reset();
    chk(sdata_oe === 1'b0, "R1 oe", 32'(sdata_oe), 0);
    chk(drdy_n === 1'b1, "R1 drdy", 32'(drdy_n), 1);
  endtask

  task automatic t_basic();
    logic [W-1:0] w = 20'hA5C3E;
    load_word(w);
    chk(drdy_n === 1'b0, "R2 drdy", 32'(drdy_n), 0);
    tick(2);
    select(w);
    shift_bits(w, 0, W-1);
    end_check(1'b1);
  endtask

  task automatic t_fall_before_rise();
    logic [W-1:0] w = 20'h3F01C;
    load_word(w);
    sclk = 1'b1;
    tick(6);
    select(w);
    sclk = 1'b0;
    tick(6);
    chk(sdata === w[W-1] && sdata_oe === 1'b1, "R5 no advance", 32'(sdata), 32'(w[W-1]));
    shift_bits(w, 0, W-1);
    end_check(1'b1);
  endtask

  task automatic t_cs_idle();
    logic [W-1:0] w = 20'hFFFFF;
    cs_n = 1'b0;
    tick(4);
    load_word(w);
    tick(6);
    chk(sdata_oe === 1'b0, "R4 ignored", 32'(sdata_oe), 0);
    chk(drdy_n === 1'b0, "R4 drdy", 32'(drdy_n), 0);
    cs_n = 1'b1;
    tick(4);
    select(w);
    shift_bits(w, 0, W-1);
    end_check(1'b1);
  endtask

  task automatic t_early_release();
    logic [W-1:0] w = 20'h5A0F3;
    load_word(w);
    tick(2);
    select(w);
    shift_bits(w, 0, 4);
    cs_n = 1'b1;
    tick(6);
    chk(sdata_oe === 1'b1, "R8 held oe", 32'(sdata_oe), 1);
    chk(sdata === w[W-1-5], "R8 held bit", 32'(sdata), 32'(w[W-1-5]));
    sclk = 1'b1;
    tick(6);
    chk(sdata === w[W-1-5] && sdata_oe === 1'b1, "R8 rise hold", 32'(sdata), 32'(w[W-1-5]));
    sclk = 1'b0;
    tick(6);
    chk(sdata_oe === 1'b0, "R8 hiz", 32'(sdata_oe), 0);
    chk(drdy_n === 1'b1, "R8 drop", 32'(drdy_n), 1);
  endtask

  task automatic t_shadow();
    logic [W-1:0] a = 20'hC3A51;
    logic [W-1:0] b = 20'h0F0F7;
    load_word(a);
    tick(2);
    select(a);
    shift_bits(a, 0, 9);
    load_word(b);
    tick(2);
    chk(drdy_n === 1'b0, "R9 drdy mid", 32'(drdy_n), 0);
    shift_bits(a, 10, W-1);
    end_check(1'b0);
    select(b);
    shift_bits(b, 0, W-1);
    end_check(1'b1);
  endtask

  task automatic t_replace();
    logic [W-1:0] a = 20'h12345;
    logic [W-1:0] b = 20'h00001;
    load_word(a);
    tick(2);
    load_word(b);
    chk(drdy_n === 1'b0, "R10 drdy", 32'(drdy_n), 0);
    tick(2);
    select(b);
    shift_bits(b, 0, W-1);
    end_check(1'b1);
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_ni = 1'b1;
    tick(4);
    t_basic();
    t_fall_before_rise();
    t_cs_idle();
    t_early_release();
    t_shadow();
    t_replace();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule